// File: doc/BRIEF.md
# Sequential Minimum-Cost Switching State Search

This block chooses, out of eight candidate switching states, the one whose predicted current error is smallest. A single cost unit is shared among all candidates. A control FSM sends the candidates to it one after another. Each cost comes back one clock later from a register, and the FSM then compares it with the lowest cost seen so far. Compared with eight parallel predictors and a wide comparator tree, this uses much less area and takes more cycles.

A one-cycle valid pulse from the preceding prediction stage starts a search. On that edge the block copies the reference dq pair and the predicted dq pair of every candidate into its own registers. The cost of a candidate is the sum of the absolute d and q errors against the reference. When the last candidate has been compared, the winning index and its cost are written to output registers, and a one-cycle done pulse tells the interval timing logic to take them.

Top module: `seq_state_search`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy_o, done_o, best_idx_o and best_cost_o are all 0.
- R2: A start_i pulse sampled while the block is idle begins a search, and busy_o is 1 from the next cycle until the search ends.
- R3: The cost of candidate i is |pred_d[i] - ref_d| + |pred_q[i] - ref_q|. All four operands are 16-bit two's complement, and the cost is a 17-bit unsigned value. Candidate i is held in bits [16*i+15:16*i] of pred_d_i and pred_q_i.
- R4: At done, best_idx_o gives the candidate with the lowest cost, and best_cost_o gives that cost.
- R5: When several candidates share the lowest cost, best_idx_o gives the one with the lowest index.
- R6: done_o is high for exactly one cycle. If start_i is sampled at clock edge 1, done_o rises at clock edge 17, which is 2*N_CAND+1 edges.
- R7: A start_i pulse sampled while busy_o is 1 is ignored. This includes the done cycle. The running search keeps its result and its timing, and no new search follows it.
- R8: The reference and table inputs are copied on the start edge. Changes to them during the search have no effect on the result.
- R9: best_idx_o and best_cost_o change only on the edge that raises done_o. They hold their values between searches.
- R10: The running minimum starts from candidate 0. If every cost is the maximum value 131070, the result is index 0 with cost 131070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Upstream valid pulse that starts a search |
| ref_d_i | input | 16 | Reference d component, signed |
| ref_q_i | input | 16 | Reference q component, signed |
| pred_d_i | input | 128 | Predicted d component of each candidate, 16 bits per candidate |
| pred_q_i | input | 128 | Predicted q component of each candidate, 16 bits per candidate |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse: the result registers have just been updated |
| best_idx_o | output | 3 | Index of the winning candidate |
| best_cost_o | output | 17 | Cost of the winning candidate |

## Verification
The bench runs equal-cost tables, both with the tie at candidate 0 and with it in the middle. A design that compares with less-or-equal would report a later index for these. A table in which every cost is at the 17-bit maximum would expose a running minimum seeded with zero, or with a constant that is too small.

Other tests pulse start again in the middle of a search while the inputs are changing, and again in the done cycle. A design that restarts would report done late or compute the result from the new inputs. A design that reads its inputs live would return the wrong winner.

Extreme operand values check that the absolute differences are formed at full width without wrapping. The bench also checks that the outputs hold their values between searches.

// File: rtl/srch_pkg.sv
package srch_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_CMP   = 2'd2,
    S_FIN   = 2'd3
  } srch_state_e;
endpackage

// File: rtl/srch_fsm.sv
module srch_fsm
  import srch_pkg::*;
#(
  parameter int N_CAND = 8,
  localparam int IDXW = $clog2(N_CAND)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            capture_o,
  output logic            issue_o,
  output logic            cmp_o,
  output logic            first_o,
  output logic            last_o,
  output logic [IDXW-1:0] cand_o,
  output logic            busy_o,
  output logic            done_o
);
  srch_state_e state_q, state_d;
  logic [IDXW-1:0] cand_q, cand_d;
  logic            cand_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_ISSUE;
      S_ISSUE: state_d = S_CMP;
      S_CMP:   state_d = last_o ? S_FIN : S_ISSUE;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign capture_o = (state_q == S_IDLE) && start_i;
  assign issue_o   = (state_q == S_ISSUE);
  assign cmp_o     = (state_q == S_CMP);
  assign done_o    = (state_q == S_FIN);
  assign busy_o    = (state_q != S_IDLE);
  assign first_o   = (cand_q == '0);
  assign last_o    = (cand_q == IDXW'(N_CAND - 1));
  assign cand_o    = cand_q;

  // Candidate counter: clear on capture, advance after each compare
  assign cand_en = capture_o || (cmp_o && !last_o);
  always_comb begin
    cand_d = cand_q;
    if (capture_o)   cand_d = '0;
    else if (cmp_o)  cand_d = cand_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cand_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cand_en) cand_q <= cand_d;
    end
  end
endmodule

// File: rtl/srch_cost_unit.sv
module srch_cost_unit #(
  parameter int DW = 16,
  localparam int CW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [DW-1:0] cand_d_i,
  input  logic [DW-1:0] cand_q_i,
  input  logic [DW-1:0] ref_d_i,
  input  logic [DW-1:0] ref_q_i,
  output logic [CW-1:0] cost_o,
  output logic          vld_o
);
  logic [DW:0]   diff_d, diff_q, neg_d, neg_q;
  logic [DW-1:0] mag_d, mag_q;
  logic [CW-1:0] cost_d;

  // Sign-extended differences never wrap at DW+1 bits
  always_comb begin
    diff_d = {cand_d_i[DW-1], cand_d_i} - {ref_d_i[DW-1], ref_d_i};
    diff_q = {cand_q_i[DW-1], cand_q_i} - {ref_q_i[DW-1], ref_q_i};
    neg_d  = '0 - diff_d;
    neg_q  = '0 - diff_q;
    mag_d  = diff_d[DW] ? neg_d[DW-1:0] : diff_d[DW-1:0];
    mag_q  = diff_q[DW] ? neg_q[DW-1:0] : diff_q[DW-1:0];
    cost_d = {1'b0, mag_d} + {1'b0, mag_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= issue_i;
      if (issue_i) cost_o <= cost_d;
    end
  end
endmodule

// File: rtl/srch_best_tracker.sv
module srch_best_tracker #(
  parameter int CW   = 17,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_i,
  input  logic            first_i,
  input  logic            last_i,
  input  logic [CW-1:0]   cost_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [IDXW-1:0] best_idx_o,
  output logic [CW-1:0]   best_cost_o
);
  logic [CW-1:0]   run_cost_q, nxt_cost;
  logic [IDXW-1:0] run_idx_q, nxt_idx;
  logic            take, res_en;

  // Strict less-than keeps the earlier candidate on a tie
  always_comb begin
    take     = first_i || (cost_i < run_cost_q);
    nxt_cost = take ? cost_i : run_cost_q;
    nxt_idx  = take ? idx_i  : run_idx_q;
    res_en   = cmp_i && last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cost_q  <= '0;
      run_idx_q   <= '0;
      best_cost_o <= '0;
      best_idx_o  <= '0;
    end else begin
      if (cmp_i) begin
        run_cost_q <= nxt_cost;
        run_idx_q  <= nxt_idx;
      end
      if (res_en) begin
        best_cost_o <= nxt_cost;
        best_idx_o  <= nxt_idx;
      end
    end
  end
endmodule

// File: rtl/seq_state_search.sv
module seq_state_search #(
  parameter int N_CAND = 8,
  parameter int DW     = 16,
  localparam int IDXW  = $clog2(N_CAND),
  localparam int CW    = DW + 1,
  localparam int TW    = N_CAND * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [DW-1:0]   ref_d_i,
  input  logic [DW-1:0]   ref_q_i,
  input  logic [TW-1:0]   pred_d_i,
  input  logic [TW-1:0]   pred_q_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [IDXW-1:0] best_idx_o,
  output logic [CW-1:0]   best_cost_o
);
  logic            capture, issue, cmp, first, last, cost_vld;
  logic [IDXW-1:0] cand;
  logic [CW-1:0]   cost;
  logic [DW-1:0]   ref_d_q, ref_q_q;
  logic [DW-1:0]   tbl_d_q [N_CAND];
  logic [DW-1:0]   tbl_q_q [N_CAND];

  srch_fsm #(.N_CAND(N_CAND)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .capture_o(capture), .issue_o(issue), .cmp_o(cmp),
    .first_o(first), .last_o(last), .cand_o(cand),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Input snapshot taken on the accepted start edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d_q <= '0;
      ref_q_q <= '0;
    end else if (capture) begin
      ref_d_q <= ref_d_i;
      ref_q_q <= ref_q_i;
    end
  end

  for (genvar g = 0; g < N_CAND; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_d_q[g] <= '0;
        tbl_q_q[g] <= '0;
      end else if (capture) begin
        tbl_d_q[g] <= pred_d_i[g*DW +: DW];
        tbl_q_q[g] <= pred_q_i[g*DW +: DW];
      end
    end
  end

  srch_cost_unit #(.DW(DW)) u_cost (
    .clk(clk), .rst_n(rst_n), .issue_i(issue),
    .cand_d_i(tbl_d_q[cand]), .cand_q_i(tbl_q_q[cand]),
    .ref_d_i(ref_d_q), .ref_q_i(ref_q_q),
    .cost_o(cost), .vld_o(cost_vld)
  );

  srch_best_tracker #(.CW(CW), .IDXW(IDXW)) u_best (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .first_i(first),
    .last_i(last), .cost_i(cost), .idx_i(cand),
    .best_idx_o(best_idx_o), .best_cost_o(best_cost_o)
  );
endmodule

// File: rtl/srch_search_checker.sv
module srch_search_checker #(
  parameter int N_CAND = 8,
  parameter int IDXW   = 3,
  parameter int CW     = 17,
  localparam int LAT   = 2 * N_CAND + 1,
  localparam int LW    = $clog2(LAT + 2) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [IDXW-1:0] best_idx_o,
  input logic [CW-1:0]   best_cost_o,
  input logic            issue,
  input logic            cost_vld
);
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lat_cnt <= '0;
    else if (start_i && !busy_o)  lat_cnt <= LW'(1);
    else if (done_o)              lat_cnt <= '0;
    else if (lat_cnt != '0)       lat_cnt <= lat_cnt + 1'b1;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_cost_registered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> cost_vld);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a restart mid-search would move done away from the fixed latency
  p_fixed_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == LW'(LAT)));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(best_idx_o) || !$stable(best_cost_o)) |-> done_o);
endmodule

bind seq_state_search srch_search_checker #(
  .N_CAND(N_CAND), .IDXW(IDXW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .best_idx_o(best_idx_o), .best_cost_o(best_cost_o),
  .issue(issue), .cost_vld(cost_vld)
);

// File: tb/seq_state_search_test.sv
`timescale 1ns/1ps
module seq_state_search_test;
  localparam int N   = 8;
  localparam int LAT = 2 * N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic signed [15:0] rd = '0, rq = '0;
  logic signed [15:0] td [N];
  logic signed [15:0] tq [N];
  logic [N*16-1:0] pd, pq;
  logic busy_o, done_o;
  logic [2:0] best_idx_o;
  logic [16:0] best_cost_o;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pd[i*16 +: 16] = td[i];
      pq[i*16 +: 16] = tq[i];
    end
  end

  seq_state_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ref_d_i(rd), .ref_q_i(rq), .pred_d_i(pd), .pred_q_i(pq),
    .busy_o(busy_o), .done_o(done_o),
    .best_idx_o(best_idx_o), .best_cost_o(best_cost_o)
  );

  // Stimulus: ref_d, ref_q, d_base, d_step, q_base, q_xor_step
  localparam logic [95:0] VEC [6] = '{
    {16'd0,      16'd0,      16'd100,    16'hFFE2, 16'd5,      16'd3},
    {16'd1000,   16'hFC18,   16'h8000,   16'd9000, 16'h7FFF,   16'h1234},
    {16'hFE0C,   16'd200,    16'd7,      16'd0,    16'd9,      16'd0},
    {16'h7FFF,   16'h8000,   16'h8000,   16'd1,    16'h7FFF,   16'd0},
    {16'd0,      16'd0,      16'h0040,   16'h0010, 16'd0,      16'h0005},
    {16'd0,      16'd0,      16'd700,    16'hFF9C, 16'd0,      16'd0}
  };

  task automatic chk(input string rq_s, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq_s, act, exp);
    end
  endtask

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model(output int idx, output int cost);
    idx = 0;
    cost = absv(int'(td[0]) - int'(rd)) + absv(int'(tq[0]) - int'(rq));
    for (int i = 1; i < N; i++) begin
      int c;
      c = absv(int'(td[i]) - int'(rd)) + absv(int'(tq[i]) - int'(rq));
      if (c < cost) begin
        cost = c;
        idx = i;
      end
    end
  endtask

  // Runs one search; optionally pulses start mid-search with scrambled inputs
  task automatic run_search(input string tag, input bit mid_start);
    int ei, ec, lat;
    model(ei, ec);
    @(negedge clk);
    start_i = 1'b1;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_i = 1'b0;
      if (lat == 1) chk({tag, " R2 busy"}, int'(busy_o), 1);
      if (mid_start && lat == 5) begin
        start_i = 1'b1;
        rd = 16'sh1111;
        rq = -16'sh0222;
        for (int i = 0; i < N; i++) begin
          td[i] = 16'(i * 4000);
          tq[i] = 16'(-i * 77);
        end
      end
      if (done_o || lat > 100) break;
    end
    chk({tag, " R6 latency"}, lat, LAT);
    chk({tag, " R4 index"}, int'(best_idx_o), ei);
    chk({tag, " R3 cost"}, int'(best_cost_o), ec);
    @(negedge clk);
    chk({tag, " R6 done pulse"}, int'(done_o), 0);
    chk({tag, " R7 idle after"}, int'(busy_o), 0);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      td[i] = '0;
      tq[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 idx", int'(best_idx_o), 0);
    chk("R1 cost", int'(best_cost_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", int'(busy_o), 0);

    // Vector walk: R3 R4 R5 cost and selection
    for (int v = 0; v < 6; v++) begin
      logic [15:0] db, ds, qb, qs;
      {rd, rq, db, ds, qb, qs} = VEC[v];
      for (int i = 0; i < N; i++) begin
        td[i] = 16'(db + ds * 16'(i));
        tq[i] = qb ^ 16'(qs * 16'(i));
      end
      run_search($sformatf("vec%0d", v), 1'b0);
    end

    // R5: tie in the middle keeps the lower index
    rd = '0; rq = '0;
    for (int i = 0; i < N; i++) begin
      td[i] = 16'sd50;
      tq[i] = '0;
    end
    td[2] = 16'sd20; td[5] = -16'sd20; td[6] = 16'sd20;
    run_search("R5 tie", 1'b0);
    chk("R5 tie index", int'(best_idx_o), 2);

    // R10: every cost at maximum
    rd = 16'sh7FFF; rq = 16'sh7FFF;
    for (int i = 0; i < N; i++) begin
      td[i] = -16'sd32768;
      tq[i] = -16'sd32768;
    end
    run_search("R10 max", 1'b0);
    chk("R10 max index", int'(best_idx_o), 0);
    chk("R10 max cost", int'(best_cost_o), 131070);

    // R7 R8: start mid-search with changed inputs is ignored
    rd = 16'sd10; rq = -16'sd10;
    for (int i = 0; i < N; i++) begin
      td[i] = 16'(300 - 40 * i);
      tq[i] = 16'(-5 * i);
    end
    run_search("R7 R8 mid start", 1'b1);

    // R9: outputs hold without a start
    begin
      int hi, hc;
      hi = int'(best_idx_o);
      hc = int'(best_cost_o);
      rd = 16'sd3;
      for (int i = 0; i < N; i++) td[i] = 16'(i);
      repeat (6) @(negedge clk);
      chk("R9 idx hold", int'(best_idx_o), hi);
      chk("R9 cost hold", int'(best_cost_o), hc);
      chk("R9 stays idle", int'(busy_o), 0);
    end

    // R7: start during the done cycle is ignored
    begin
      int lat;
      @(negedge clk);
      start_i = 1'b1;
      lat = 0;
      while (1) begin
        @(posedge clk);
        lat++;
        @(negedge clk);
        start_i = 1'b0;
        if (done_o || lat > 100) break;
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 start in done cycle", int'(busy_o), 0);
      @(negedge clk);
      chk("R7 no late done", int'(done_o), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule